// File: doc/BRIEF.md
# Lockable Watchdog Timer with Software Reset

This block is a watchdog timer on a simple peripheral register bus. It occupies one byte address. Software uses that byte to set a reload period, to start the timer, to refresh the timer while it runs and to request a reset on purpose. Once the timer is started, software cannot stop it. Only a reset puts it back to idle, whether that reset comes from the system or from the watchdog itself.

A prescaler divides the clock into ticks. A 6-bit down counter counts those ticks. The watchdog raises a one-cycle reset request in three cases:
- the counter runs out;
- software writes the reset code;
- a stop/halt request arrives while the timer is running.

In the same cycle that the request pulse appears, the block has already returned to its reset state. That state is idle, with the longest period loaded.

Top module: `wdt_lock`

## Requirements
- R1: Only writes and reads at byte address 0x12 reach the register. A write to any other address changes nothing. A read at 0x12 returns {reload[5:0], 1'b0, enable} on bits 7:2, 1 and 0. Any other address reads as zero.
- R2: A write at 0x12 while idle with bit0 = 1 and bit1 = 1 does three things: it sets the enable bit, it loads the counter from bits 7:2, and it stores bits 7:2 as the reload value.
- R3: While running, a write with bit0 = 0 and bit1 = 0 has no effect. The enable bit stays set until a reset request or a system reset.
- R4: After a system reset, and in the cycle a reset request pulse is visible, the enable bit is 0 and the reload value is 63. The register then reads 0xFC.
- R5: Suppose the timer is started or refreshed with reload N. If nothing else happens, the reset request goes high exactly (N+1)*PRESCALE clock cycles after the clock edge that accepted the write.
- R6: A write at 0x12 with bit0 = 1 and bit1 = 0 raises the reset request one cycle later. This holds whether the timer is idle or running.
- R7: A halt request while running raises the reset request one cycle later. A halt request while idle has no effect.
- R8: A write with bit1 = 1 while running restarts the period from bits 7:2 and stores them as the reload value. The timer stays enabled.
- R9: The reset request is a single-cycle pulse. It is never high in two consecutive cycles.
- R10: A write while idle with bit0 = 0 stores bits 7:2 as the reload value and leaves the timer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, synchronous |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when the address does not match |
| halt_req | input | 1 | Stop/halt request from the core |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume three things about the inputs:
- bus inputs and the halt request are stable across each rising edge;
- each bus access lasts one cycle;
- the halt assertion applies only in cycles with no bus access, because a write in the same cycle could itself fire.

The stimulus changes every input at the falling edge. It drives one access per task call and sends halt requests with the bus idle. A behavioural reference model computes each deadline as an absolute cycle number. That model is compared with the reset request and the read data on every clock.

// File: rtl/wdt_lock.sv
module wdt_lock #(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ADDR = 8'h12,
  parameter int RELOAD_W = 6,
  parameter int PRESCALE = 24576
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [RELOAD_W+1:0]   bus_wdata,
  output logic [RELOAD_W+1:0]   bus_rdata,
  input  logic                  halt_req,
  output logic                  rst_req
);
  localparam int DATA_W = RELOAD_W + 2;
  localparam int PRE_W  = $clog2(PRESCALE + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic                en_q;
  logic [RELOAD_W-1:0] reload_q, cnt_q;
  logic [PRE_W-1:0]    pre_q;

  logic addr_hit, wr_hit, swrst, tick, expire, fire, start, refresh, store;
  logic [RELOAD_W-1:0] wval;

  assign addr_hit = bus_sel && (bus_addr == ADDR);
  assign wr_hit   = addr_hit && bus_wr;
  assign wval     = bus_wdata[DATA_W-1:2];
  assign swrst    = wr_hit && bus_wdata[0] && !bus_wdata[1];
  assign tick     = en_q && (pre_q == PRE_LAST);
  assign expire   = tick && (cnt_q == '0);
  assign fire     = swrst || (en_q && halt_req) || expire;
  assign start    = wr_hit && !en_q && bus_wdata[0] && bus_wdata[1];
  assign refresh  = wr_hit && en_q && bus_wdata[1];
  assign store    = wr_hit && !en_q && !bus_wdata[0];

  assign bus_rdata = addr_hit ? {reload_q, 1'b0, en_q} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      reload_q <= '1;
      cnt_q    <= '1;
      pre_q    <= '0;
      rst_req  <= 1'b0;
    end else begin
      rst_req <= fire && !rst_req;
      if (fire) begin
        en_q     <= 1'b0;
        reload_q <= '1;
        cnt_q    <= '1;
        pre_q    <= '0;
      end else if (start || refresh) begin
        en_q     <= 1'b1;
        reload_q <= wval;
        cnt_q    <= wval;
        pre_q    <= '0;
      end else if (store) begin
        reload_q <= wval;
      end else if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else if (en_q) begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  AST_STICKY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> (en_q || rst_req)); // R3
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_CLEAR_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!en_q && (&reload_q))); // R4
  AST_SW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR && bus_wdata[0] && !bus_wdata[1] && !rst_req)
    |=> rst_req); // R6
  AST_HALT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && en_q && !rst_req) |=> rst_req); // R7
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !en_q && !bus_sel) |=> !rst_req); // R7
  AST_IDLE_PRESCALER: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pre_q == '0)); // R5
endmodule

// File: tb/wdt_lock_bench.sv
module wdt_lock_bench;
  localparam int P = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, halt_req = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic rst_req;
  int checks = 0, errors = 0, cyc = 0;
  string tag = "R4";

  int m_en = 0, m_reload = 63, m_rst = 0;
  longint m_deadline = -1;

  wdt_lock #(.PRESCALE(P)) u_wdt_lock (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .halt_req(halt_req), .rst_req(rst_req));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    int hit, fire, n;
    logic [7:0] exp_rd;
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_reload = 63; m_rst = 0; m_deadline = -1;
    end else begin
      hit = bus_sel && bus_wr && bus_addr == 8'h12;
      n = bus_wdata[7:2];
      fire = 0;
      if (hit && bus_wdata[0] && !bus_wdata[1]) fire = 1;
      if (m_en && halt_req) fire = 1;
      if (m_en && cyc == m_deadline) fire = 1;
      if (fire) begin
        m_rst = !m_rst;
        m_en = 0; m_reload = 63; m_deadline = -1;
      end else begin
        m_rst = 0;
        if (hit && !m_en) begin
          m_reload = n;
          if (bus_wdata[0] && bus_wdata[1]) begin
            m_en = 1; m_deadline = cyc + (n + 1) * P;
          end
        end else if (hit && bus_wdata[1]) begin
          m_reload = n; m_deadline = cyc + (n + 1) * P;
        end
      end
    end
    #3;
    exp_rd = (bus_sel && bus_addr == 8'h12) ? {m_reload[5:0], 1'b0, m_en[0]} : 8'h00;
    checks++;
    if (rst_req !== m_rst[0] || bus_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s cycle %0d rst_req=%b exp %b rdata=%h exp %h",
               tag, cyc, rst_req, m_rst[0], bus_rdata, exp_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1; checks++;
    if (bus_rdata !== e) begin
      errors++; $display("FAIL %s read=%h exp %h", t, bus_rdata, e);
    end
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++; $display("FAIL %s value=%b exp %b", t, act, e);
    end
  endtask

  task automatic wait_pulse(input int exp_n, input string t);
    int n = 0;
    while (!rst_req && n < 2000) begin @(negedge clk); n++; end
    checks++;
    if (n != exp_n) begin
      errors++; $display("FAIL %s cycles=%0d exp %0d", t, n, exp_n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R4"; rd(8'h12, 8'hFC, "R4 reset state");
    tag = "R10"; wr(8'h12, 8'h0C); rd(8'h12, 8'h0C, "R10 idle store");
    chk(rst_req, 1'b0, "R10 no request");
    tag = "R1"; wr(8'h13, 8'hFF); rd(8'h12, 8'h0C, "R1 other address");
    rd(8'h13, 8'h00, "R1 other read");
    tag = "R7"; @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
    chk(rst_req, 1'b0, "R7 idle halt"); rd(8'h12, 8'h0C, "R7 idle halt state");
    tag = "R2"; wr(8'h12, 8'h0F);
    tag = "R5"; wait_pulse(4 * P, "R5 timeout N=3");
    tag = "R4"; #1; rd(8'h12, 8'hFC, "R4 after timeout");
    tag = "R2"; wr(8'h12, 8'h07); rd(8'h12, 8'h05, "R2 started");
    tag = "R3"; wr(8'h12, 8'h00); rd(8'h12, 8'h05, "R3 sticky enable");
    tag = "R8"; wr(8'h12, 8'h16);
    tag = "R5"; wait_pulse(6 * P, "R5 R8 refreshed timeout N=5");
    tag = "R9"; @(negedge clk); chk(rst_req, 1'b0, "R9 single pulse");
    tag = "R6"; wr(8'h12, 8'h01); chk(rst_req, 1'b1, "R6 idle sw reset");
    wr(8'h12, 8'h0B); wr(8'h12, 8'h01); chk(rst_req, 1'b1, "R6 running sw reset");
    tag = "R7"; wr(8'h12, 8'h3F); repeat (5) @(negedge clk);
    halt_req = 1; @(negedge clk); halt_req = 0; chk(rst_req, 1'b1, "R7 running halt");
    @(negedge clk); chk(rst_req, 1'b0, "R9 halt pulse ends");
    tag = "R4"; wr(8'h12, 8'h23); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(8'h12, 8'hFC, "R4 system reset");
    repeat (100) @(negedge clk); chk(rst_req, 1'b0, "R4 stays idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule